// File: doc/BRIEF.md
# Compressed Elapsed Cycle Counter

This block measures how many active cycles pass between two consecutive recorded control transfers, and hands the measurement to the record that closes the interval. The count is kept in a saturating up-counter. When a record strobe arrives, the count is packed into a 16-bit code in a floating-point style. The code holds an exponent field and a 12-bit mantissa field. Large counts therefore lose their low-order bits instead of needing a wide field in every stored record.

A flag travels with every code. The flag says whether the interval was measured in full. After reset, after a write to the recording configuration, or after a clear, the interval that is running is not trustworthy. The next record therefore carries the flag at 0. Every record after that carries it at 1, until the next reset, configuration write or clear.

The result leaves the block as a stream that carries a valid bit but no ready input. A record cannot be held back once its transfer has retired, so the block applies no back-pressure. The consumer must accept each result in the cycle in which `res_valid_o` is high. The control inputs are plain level or strobe pins.

Top module: `cycle_span_coder`

## Requirements
- R1: While the count is below 4096, the code has exponent 0 (code bits [15:12]) and mantissa equal to the count (code bits [11:0]).
- R2: For a count of 4096 or more, the exponent e is the position of the highest set bit of the count minus 11. The mantissa is count bits [e+10 : e-1]. Decoding (4096 + mantissa) << (e - 1) therefore gives the count with its e-1 lowest bits dropped. Examples: 4096 gives 0x1000, 8191 gives 0x1FFF, 8192 gives 0x2000 and 10001 gives 0x2388.
- R3: The parameter EXP_BITS (0 to 4) sets the counter width to 12, 13, 15, 19 or 27 bits respectively. The exponent never exceeds 2^EXP_BITS - 1, so the exponent bits that are not implemented read 0.
- R4: The counter stops at its all-ones value instead of wrapping. A record taken there reports every implemented exponent bit and every mantissa bit as 1. With EXP_BITS = 2 that code is 0x3FFF.
- R5: The counter advances only in cycles where `rec_active_i` is 1. Inactive cycles leave the count unchanged.
- R6: A record reports the number of active cycles counted before the record cycle since the last restart. The record cycle itself is not counted. The counter then restarts from 0, so back-to-back records report 0.
- R7: The valid flag is 0 after reset, after `cfg_write_i` and after `clear_i`. A record sets it to 1. Each result carries the flag value that held before its record cycle.
- R8: When a record falls in the same cycle as `clear_i` or `cfg_write_i`, the result carries the count and flag from before that cycle. The counter and the flag are still cleared, so the following record reports the new interval with the flag at 0.
- R9: `res_valid_o` is high for exactly one cycle, in the cycle after each record strobe, and is low at all other times. It is low out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_active_i | input | 1 | High while recording is active (mode enabled and not frozen); counts as a cycle enable |
| rec_strobe_i | input | 1 | A transfer is recorded in this cycle |
| cfg_write_i | input | 1 | The recording configuration was written; restarts the interval and clears the flag |
| clear_i | input | 1 | Record buffer clear; restarts the interval and clears the flag |
| res_valid_o | output | 1 | One-cycle pulse: a result is presented (no ready; must be taken) |
| res_code_o | output | 16 | Compressed count: [15:12] exponent, [11:0] mantissa |
| res_ccv_o | output | 1 | Count-valid flag of the presented result |

## Verification
A record strobe and a restart (clear or configuration write) can fall in the same cycle. The two disagree about which interval the result belongs to. The bench provokes this by running a known number of active cycles and then asserting the record strobe together with each restart input in turn. The scoreboard expects that result to carry the old count and a flag of 1. It expects the record after it to carry only the new active cycles, with the flag at 0.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int MANT_W = 12;
  localparam int EXPO_W = 4;
  localparam int CODE_W = MANT_W + EXPO_W;

  typedef struct packed {
    logic [EXPO_W-1:0] expo;
    logic [MANT_W-1:0] mant;
  } span_code_t;

  // Counter width needed for a given number of implemented exponent bits.
  function automatic int span_width(input int exp_bits);
    case (exp_bits)
      0:       span_width = 12;
      1:       span_width = 13;
      2:       span_width = 15;
      3:       span_width = 19;
      default: span_width = 27;
    endcase
  endfunction

endpackage

// File: rtl/csc_counter.sv
module csc_counter #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (restart_i) begin
      count_q <= '0;
    end else if (tick_i && (count_q != CNT_MAX)) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;

  // R4: at the top value the count stays put
  a_r4_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNT_MAX && !restart_i) |=> (count_q == CNT_MAX));

  // R5: no advance while inactive
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i) |=> $stable(count_q));

  // R6: restart empties the counter
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (count_q == '0));

endmodule

// File: rtl/csc_encoder.sv
module csc_encoder
  import csc_pkg::*;
#(
  parameter int EXP_BITS = 3,
  parameter int CNT_W    = span_width(EXP_BITS)
) (
  input  logic [CNT_W-1:0] count_i,
  output span_code_t       code_o
);

  generate
    if (EXP_BITS == 0) begin : g_plain
      assign code_o.expo = '0;
      assign code_o.mant = count_i[MANT_W-1:0];
    end else begin : g_float
      logic [EXPO_W-1:0] expo;
      logic [MANT_W-1:0] mant;

      always_comb begin
        expo = '0;
        for (int b = MANT_W; b < CNT_W; b++) begin
          if (count_i[b]) expo = EXPO_W'(b - MANT_W + 1);
        end
        if (expo == '0) mant = count_i[MANT_W-1:0];
        else            mant = MANT_W'(count_i >> (expo - 1'b1));
      end

      assign code_o.expo = expo;
      assign code_o.mant = mant;
    end
  endgenerate

endmodule

// File: rtl/csc_flag.sv
module csc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic drop_i,
  input  logic set_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (drop_i) flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  // R7: a restart always leaves the flag low
  a_r7_drop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> !flag_q);

  // R7: a lone record raises the flag
  a_r7_set_on_record: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !drop_i) |=> flag_q);

endmodule

// File: rtl/cycle_span_coder.sv
module cycle_span_coder
  import csc_pkg::*;
#(
  parameter int EXP_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_active_i,
  input  logic              rec_strobe_i,
  input  logic              cfg_write_i,
  input  logic              clear_i,
  output logic              res_valid_o,
  output logic [CODE_W-1:0] res_code_o,
  output logic              res_ccv_o
);

  localparam int                CNT_W    = span_width(EXP_BITS);
  localparam logic [EXPO_W-1:0] EXPO_TOP = EXPO_W'((1 << EXP_BITS) - 1);

  logic             drop;
  logic             restart;
  logic [CNT_W-1:0] count;
  logic             flag;
  span_code_t       code;

  assign drop    = clear_i | cfg_write_i;
  assign restart = drop | rec_strobe_i;

  csc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (rec_active_i),
    .restart_i (restart),
    .count_o   (count)
  );

  csc_encoder #(.EXP_BITS(EXP_BITS), .CNT_W(CNT_W)) u_encoder (
    .count_i (count),
    .code_o  (code)
  );

  csc_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .drop_i (drop),
    .set_i  (rec_strobe_i),
    .flag_o (flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_code_o  <= '0;
      res_ccv_o   <= 1'b0;
    end else begin
      res_valid_o <= rec_strobe_i;
      if (rec_strobe_i) begin
        res_code_o <= code;
        res_ccv_o  <= flag;
      end
    end
  end

  // R1: small counts pass through unchanged
  a_r1_small_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(count) < 32'd4096) |-> (code.expo == '0 && code.mant == count[MANT_W-1:0]));

  // R2: large counts always use a nonzero exponent
  a_r2_large_scaled: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(count) >= 32'd4096) |-> (code.expo != '0));

  // R3: exponent limited to implemented bits
  a_r3_expo_range: assert property (@(posedge clk) disable iff (!rst_n)
    code.expo <= EXPO_TOP);

  // R8: a restart empties both counter and flag, even alongside a record
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (count == '0 && !flag));

  // R9: one result pulse per record, one cycle later
  a_r9_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rec_strobe_i |=> res_valid_o);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_strobe_i |=> !res_valid_o);

endmodule

// File: tb/cycle_span_coder_test.sv
module cycle_span_coder_test;

  localparam int EXP_BITS = 2;
  localparam int CNT_MAX  = (1 << 15) - 1;

  typedef struct {
    logic [15:0] code;
    logic        ccv;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act = 1'b0, rec = 1'b0, cfg = 1'b0, clr = 1'b0;
  logic        res_valid;
  logic [15:0] res_code;
  logic        res_ccv;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   cycles = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  int m_cnt = 0;
  bit m_ccv = 1'b0;

  always #2 clk = ~clk;

  cycle_span_coder #(.EXP_BITS(EXP_BITS)) uut (
    .clk(clk), .rst_n(rst_n), .rec_active_i(act), .rec_strobe_i(rec),
    .cfg_write_i(cfg), .clear_i(clr), .res_valid_o(res_valid),
    .res_code_o(res_code), .res_ccv_o(res_ccv)
  );

  // Expected code from the decode rule: find e so that (4096+m)<<(e-1) covers c
  function automatic logic [15:0] expect_code(input int c);
    int e;
    if (c < 4096) return 16'(c);
    e = 1;
    while (c >= (8192 << (e - 1))) e++;
    return {4'(e), 12'((c >> (e - 1)) - 4096)};
  endfunction

  task automatic step(input bit a, input bit r, input bit cl, input bit cf, input string tag);
    exp_t it;
    @(negedge clk);
    act = a; rec = r; clr = cl; cfg = cf;
    if (r) begin
      it.code = expect_code(m_cnt);
      it.ccv  = m_ccv;
      it.tag  = tag;
      sb.push_back(it);
    end
    if (cl || cf) begin
      m_cnt = 0; m_ccv = 1'b0;
    end else if (r) begin
      m_cnt = 0; m_ccv = 1'b1;
    end else if (a && m_cnt < CNT_MAX) begin
      m_cnt++;
    end
  endtask

  task automatic run(input int n, input bit a);
    for (int i = 0; i < n; i++) step(a, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act_v, exp_v);
    end
  endtask

  // Monitor: compare each presented result with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected result", 1, 0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(res_code == it.code, {it.tag, " code"}, res_code, it.code);
        check(res_ccv == it.ccv, {it.tag, " flag"}, res_ccv, it.ccv);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 200000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R9 reset valid", res_valid, 0);
    check(res_code == 16'h0, "R7 reset code", res_code, 0);
    @(negedge clk);
    rst_n = 1'b1;

    run(10, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R1 R7 first record after reset");
    for (int i = 0; i < 50; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, "");
      step(1'b0, 1'b0, 1'b0, 1'b0, "");
    end
    step(1'b1, 1'b1, 1'b0, 1'b0, "R5 gated count");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R6 back-to-back");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R6 back-to-back 2");
    run(4095, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, "R1 count 4095");
    run(4096, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, "R2 count 4096");
    run(8191, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, "R2 count 8191");
    run(8192, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, "R2 count 8192");
    run(10001, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R2 count 10001");
    run(40000, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, "R4 R3 saturated");
    run(7, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1, "");
    run(3, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, "R7 after config write");
    run(9, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b0, "");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R7 after clear");
    run(20, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b0, "R8 record with clear");
    run(5, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, "R8 interval after clear");
    run(12, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, "R8 flag back to 1");
    run(30, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1, "R8 record with config write");
    run(2, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R8 interval after config write");
    run(6, 1'b0);
    check(sb.size() == 0, "R9 every record answered", sb.size(), 0);
    check(res_valid == 1'b0, "R9 idle valid low", res_valid, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule